// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block sits behind a byte-level I2C target engine and turns a handful of directly addressed 16-bit registers into a gateway to a 32-bit internal memory space. The host loads a write pointer or a read pointer, one 16-bit half at a time. It then moves 16-bit words through a single data-port register. After every data-port access, the matching pointer steps forward by one word, so a stream of words at consecutive addresses needs only one pointer setup.

The engine reports start (or repeated start) with the transfer direction, stop, each received byte, and each request for the next byte to send. The bridge gathers a 16-bit register address and 16-bit values, most significant byte first. It drives a single-cycle internal bus with address, write data, write enable, read enable and read data. For a read, the host writes the register address and then issues a repeated start in read mode. The bridge fetches the word as that read begins and shifts it out high byte first. A separate page register, readable and writable, holds the upper address half used for hardware-register accesses.

Top module: `regwin_bridge`

## Requirements
- R1: A write transaction sends two register-address bytes, then value bytes, each 16-bit quantity most significant byte first. A value takes effect on the byte that completes it.
- R2: Register 0x0028 holds bits 31:16 of the write pointer and 0x002A holds bits 15:0. Register 0x002C holds bits 31:16 of the read pointer and 0x002E holds bits 15:0. All four read back their current value.
- R3: Writing one half of a pointer leaves the other half unchanged.
- R4: A value written to data port 0x0F12 raises o_mem_we for exactly the cycle of the completing byte, with o_mem_addr equal to the write pointer. The write pointer then grows by 2 as a full 32-bit sum, so a carry passes from the low half into the high half.
- R5: A read-mode start while the register address is 0x0F12 raises o_mem_re for that one cycle, with o_mem_addr equal to the read pointer. The bridge latches i_mem_rdata in the same cycle, and the read pointer then grows by 2.
- R6: A read returns the latched word high byte first. Each byte request toggles between the high and low bytes, so a third byte repeats the high byte.
- R7: Register 0xFCFC is a readable and writable page register that resets to 0xD000.
- R8: A register address outside the defined set accepts writes without effect and without bus activity, and reads as 0x0000.
- R9: Further value words in the same write transaction each commit to the same register address. On the data port, they fill consecutive words.
- R10: A stop, or a write-mode start, returns byte assembly to the address phase. A read-mode start uses the last register address received.
- R11: o_mem_we and o_mem_re are never high together, and both are low during and after reset until an access occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_start | input | 1 | One-cycle start or repeated-start event |
| i_stop | input | 1 | One-cycle stop event |
| i_rnw | input | 1 | Direction of the transfer opened by i_start (1 = read) |
| i_wr_vld | input | 1 | A byte from the host is valid |
| i_wr_byte | input | 8 | Byte from the host |
| i_rd_req | input | 1 | The engine has taken the current read byte |
| o_rd_byte | output | 8 | Byte for the engine to shift out |
| o_mem_addr | output | 32 | Internal bus address |
| o_mem_wdata | output | 16 | Internal bus write data |
| o_mem_we | output | 1 | Internal bus write strobe |
| o_mem_re | output | 1 | Internal bus read strobe |
| i_mem_rdata | input | 16 | Internal bus read data, valid in the same cycle |

## Verification
The bench builds the bridge with its default pointer step of 2 and a page reset value of 0xD000. It therefore checks word-sized pointer movement, including the carry from 0x????FFFE into the high half, against a behavioural model of both pointers and of memory. The default two-stage reset synchronizer means the first transaction can start only after the internal release. Back-to-back bytes within a burst exercise the strobe-per-word behaviour at full byte rate.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int PTR_W  = 32;

  localparam logic [WORD_W-1:0] RA_PORT = 16'h0F12;
  localparam logic [WORD_W-1:0] RA_PAGE = 16'hFCFC;
  // index 0 = write pointer, index 1 = read pointer
  localparam logic [1:0][WORD_W-1:0] PTR_HI_RA = {16'h002C, 16'h0028};
  localparam logic [1:0][WORD_W-1:0] PTR_LO_RA = {16'h002E, 16'h002A};

  typedef enum logic [1:0] {PH_AHI, PH_ALO, PH_DHI, PH_DLO} phase_e;
endpackage

// File: rtl/regwin_rxframe.sv
module regwin_rxframe
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_start,
  input  logic              i_stop,
  input  logic              i_rnw,
  input  logic              i_wr_vld,
  input  logic [BYTE_W-1:0] i_wr_byte,
  output logic [WORD_W-1:0] o_reg_addr,
  output logic              o_commit,
  output logic [WORD_W-1:0] o_wr_data
);
  phase_e              phase_q, phase_d;
  logic [BYTE_W-1:0]   hold_q, hold_d;
  logic [WORD_W-1:0]   addr_q, addr_d;
  logic                en;

  always_comb begin
    phase_d  = phase_q;
    hold_d   = hold_q;
    addr_d   = addr_q;
    o_commit = 1'b0;
    if (i_stop || (i_start && !i_rnw)) begin
      phase_d = PH_AHI;
    end else if (i_wr_vld) begin
      unique case (phase_q)
        PH_AHI: begin hold_d = i_wr_byte; phase_d = PH_ALO; end
        PH_ALO: begin addr_d = {hold_q, i_wr_byte}; phase_d = PH_DHI; end
        PH_DHI: begin hold_d = i_wr_byte; phase_d = PH_DLO; end
        PH_DLO: begin o_commit = 1'b1; phase_d = PH_DHI; end
        default: phase_d = PH_AHI;
      endcase
    end
  end

  assign en         = i_wr_vld | i_stop | i_start;
  assign o_reg_addr = addr_q;
  assign o_wr_data  = {hold_q, i_wr_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AHI;
      hold_q  <= '0;
      addr_q  <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
      addr_q  <= addr_d;
    end
  end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr
  import regwin_pkg::*;
#(
  parameter logic [WORD_W-1:0] HI_RA = 16'h0028,
  parameter logic [WORD_W-1:0] LO_RA = 16'h002A,
  parameter int                STEP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_commit,
  input  logic [WORD_W-1:0] i_reg_addr,
  input  logic [WORD_W-1:0] i_wr_data,
  input  logic              i_adv,
  output logic [PTR_W-1:0]  o_ptr
);
  localparam logic [PTR_W-1:0] INC = PTR_W'(STEP);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             en;

  always_comb begin
    ptr_d = ptr_q;
    if (i_commit && i_reg_addr == HI_RA)      ptr_d[PTR_W-1:WORD_W] = i_wr_data;
    else if (i_commit && i_reg_addr == LO_RA) ptr_d[WORD_W-1:0]     = i_wr_data;
    else if (i_adv)                           ptr_d = ptr_q + INC;
  end

  assign en    = i_commit | i_adv;
  assign o_ptr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/regwin_rdlatch.sv
module regwin_rdlatch
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_load,
  input  logic [WORD_W-1:0] i_word,
  input  logic              i_next,
  output logic [BYTE_W-1:0] o_byte
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              lo_q, lo_d;

  always_comb begin
    word_d = word_q;
    lo_d   = lo_q;
    if (i_load) begin
      word_d = i_word;
      lo_d   = 1'b0;
    end else if (i_next) begin
      lo_d   = ~lo_q;
    end
  end

  assign o_byte = lo_q ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lo_q   <= 1'b0;
    end else if (i_load || i_next) begin
      word_q <= word_d;
      lo_q   <= lo_d;
    end
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int                STEP        = 2,
  parameter logic [WORD_W-1:0] PAGE_RST    = 16'hD000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_start,
  input  logic              i_stop,
  input  logic              i_rnw,
  input  logic              i_wr_vld,
  input  logic [7:0]        i_wr_byte,
  input  logic              i_rd_req,
  output logic [7:0]        o_rd_byte,
  output logic [31:0]       o_mem_addr,
  output logic [15:0]       o_mem_wdata,
  output logic              o_mem_we,
  output logic              o_mem_re,
  input  logic [15:0]       i_mem_rdata
);
  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  logic [WORD_W-1:0] reg_addr, wr_data, rd_val;
  logic              commit, fetch, port_wr, port_rd;
  logic [1:0]        adv;
  logic [PTR_W-1:0]  ptrs [2];
  logic [WORD_W-1:0] page_q, page_d;
  logic              page_en;

  regwin_rxframe u_rx (
    .clk(clk), .rst_n(rst_int_n), .i_start(i_start), .i_stop(i_stop),
    .i_rnw(i_rnw), .i_wr_vld(i_wr_vld), .i_wr_byte(i_wr_byte),
    .o_reg_addr(reg_addr), .o_commit(commit), .o_wr_data(wr_data)
  );

  assign fetch   = i_start & i_rnw;
  assign port_wr = commit & (reg_addr == RA_PORT);
  assign port_rd = fetch & (reg_addr == RA_PORT) & ~commit;
  assign adv     = {port_rd, port_wr};

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    regwin_ptr #(.HI_RA(PTR_HI_RA[g]), .LO_RA(PTR_LO_RA[g]), .STEP(STEP)) u_ptr (
      .clk(clk), .rst_n(rst_int_n), .i_commit(commit), .i_reg_addr(reg_addr),
      .i_wr_data(wr_data), .i_adv(adv[g]), .o_ptr(ptrs[g])
    );
  end

  // page register for hardware-register accesses
  assign page_en = commit & (reg_addr == RA_PAGE);
  always_comb begin
    page_d = page_q;
    if (page_en) page_d = wr_data;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   page_q <= PAGE_RST;
    else if (page_en) page_q <= page_d;
  end

  always_comb begin
    rd_val = '0;
    if      (reg_addr == PTR_HI_RA[0]) rd_val = ptrs[0][PTR_W-1:WORD_W];
    else if (reg_addr == PTR_LO_RA[0]) rd_val = ptrs[0][WORD_W-1:0];
    else if (reg_addr == PTR_HI_RA[1]) rd_val = ptrs[1][PTR_W-1:WORD_W];
    else if (reg_addr == PTR_LO_RA[1]) rd_val = ptrs[1][WORD_W-1:0];
    else if (reg_addr == RA_PORT)      rd_val = i_mem_rdata;
    else if (reg_addr == RA_PAGE)      rd_val = page_q;
  end

  regwin_rdlatch u_rd (
    .clk(clk), .rst_n(rst_int_n), .i_load(fetch), .i_word(rd_val),
    .i_next(i_rd_req), .o_byte(o_rd_byte)
  );

  assign o_mem_addr  = port_wr ? ptrs[0] : ptrs[1];
  assign o_mem_wdata = wr_data;
  assign o_mem_we    = port_wr;
  assign o_mem_re    = port_rd;
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       i_start,
  input logic       i_rnw,
  input logic       i_wr_vld,
  input logic       i_rd_req,
  input logic [7:0] o_rd_byte,
  input logic       o_mem_we,
  input logic       o_mem_re
);
  a_r11_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(o_mem_we && o_mem_re));

  a_r4_we_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    o_mem_we |-> i_wr_vld);

  a_r4_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    o_mem_we |=> !o_mem_we);

  a_r5_re_on_read_start: assert property (@(posedge clk) disable iff (!rst_n)
    o_mem_re |-> (i_start && i_rnw));

  a_r6_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_start && !i_rd_req) |=> $stable(o_rd_byte));
endmodule

bind regwin_bridge regwin_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_rnw(i_rnw),
  .i_wr_vld(i_wr_vld), .i_rd_req(i_rd_req), .o_rd_byte(o_rd_byte),
  .o_mem_we(o_mem_we), .o_mem_re(o_mem_re)
);

// File: tb/tb_regwin_bridge.sv
module tb_regwin_bridge;
  localparam int CLK_PER = 10;
  localparam logic [15:0] A_WH = 16'h0028, A_WL = 16'h002A, A_RH = 16'h002C,
                          A_RL = 16'h002E, A_PORT = 16'h0F12, A_PAGE = 16'hFCFC;

  logic clk = 1'b0;
  logic rst_n;
  logic i_start, i_stop, i_rnw, i_wr_vld, i_rd_req;
  logic [7:0]  i_wr_byte, o_rd_byte;
  logic [31:0] o_mem_addr;
  logic [15:0] o_mem_wdata, mem_rdata;
  logic o_mem_we, o_mem_re;

  always #(CLK_PER/2) clk = ~clk;

  regwin_bridge dut (
    .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop), .i_rnw(i_rnw),
    .i_wr_vld(i_wr_vld), .i_wr_byte(i_wr_byte), .i_rd_req(i_rd_req),
    .o_rd_byte(o_rd_byte), .o_mem_addr(o_mem_addr), .o_mem_wdata(o_mem_wdata),
    .o_mem_we(o_mem_we), .o_mem_re(o_mem_re), .i_mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_init(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C3C;
  endfunction

  // memory slave driven by the design's bus
  logic [15:0] slave_mem [logic [31:0]];
  bit wr_tick = 1'b0;
  always @(posedge clk) if (o_mem_we) begin
    slave_mem[o_mem_addr] = o_mem_wdata;
    wr_tick = ~wr_tick;
  end
  always @(o_mem_addr, o_mem_re, wr_tick)
    mem_rdata = slave_mem.exists(o_mem_addr) ? slave_mem[o_mem_addr] : mem_init(o_mem_addr);

  // reference model
  logic [31:0] m_wp = '0, m_rp = '0;
  logic [15:0] m_page = 16'hD000;
  logic [15:0] m_mem [logic [31:0]];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  logic exp_we = 1'b0, exp_re = 1'b0;
  logic [31:0] exp_addr = '0;
  logic [15:0] exp_wd = '0;

  function automatic logic [15:0] m_val(input logic [15:0] ra);
    case (ra)
      A_WH: return m_wp[31:16];
      A_WL: return m_wp[15:0];
      A_RH: return m_rp[31:16];
      A_RL: return m_rp[15:0];
      A_PAGE: return m_page;
      A_PORT: return m_mem.exists(m_rp) ? m_mem[m_rp] : mem_init(m_rp);
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_commit(input logic [15:0] ra, input logic [15:0] v);
    case (ra)
      A_WH: m_wp[31:16] = v;
      A_WL: m_wp[15:0] = v;
      A_RH: m_rp[31:16] = v;
      A_RL: m_rp[15:0] = v;
      A_PAGE: m_page = v;
      A_PORT: begin m_mem[m_wp] = v; m_wp = m_wp + 32'd2; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // bus compared on every clock (R4 R5 R8 R11)
  always @(negedge clk) if (cmp_en && !done) begin
    #2;
    n_cmp++;
    if (o_mem_we !== exp_we || o_mem_re !== exp_re ||
        ((exp_we || exp_re) && o_mem_addr !== exp_addr) ||
        (exp_we && o_mem_wdata !== exp_wd)) begin
      n_bad++;
      $display("FAIL R4 R5 R8 R11 bus: got we=%b re=%b a=%h d=%h expected we=%b re=%b a=%h d=%h",
               o_mem_we, o_mem_re, o_mem_addr, o_mem_wdata, exp_we, exp_re, exp_addr, exp_wd);
    end
  end

  task automatic drive(input logic st, sp, rnw, vld, input logic [7:0] b, input logic rq,
                       input logic ewe, ere, input logic [31:0] ea, input logic [15:0] ewd);
    @(negedge clk);
    i_start = st; i_stop = sp; i_rnw = rnw; i_wr_vld = vld; i_wr_byte = b; i_rd_req = rq;
    exp_we = ewe; exp_re = ere; exp_addr = ea; exp_wd = ewd;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 8'h00, 0, 0, 0, '0, '0);
  endtask

  task automatic send_addr(input logic [15:0] ra);
    drive(1, 0, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    drive(0, 0, 0, 1, ra[15:8], 0, 0, 0, '0, '0);
    drive(0, 0, 0, 1, ra[7:0], 0, 0, 0, '0, '0);
  endtask

  task automatic send_word(input logic [15:0] ra, input logic [15:0] v);
    logic isport;
    isport = (ra == A_PORT);
    drive(0, 0, 0, 1, v[15:8], 0, 0, 0, '0, '0);
    drive(0, 0, 0, 1, v[7:0], 0, isport, 0, m_wp, v);
    m_commit(ra, v);
  endtask

  // R1: address then value, both MSB first
  task automatic reg_wr(input logic [15:0] ra, input logic [15:0] v);
    send_addr(ra);
    send_word(ra, v);
    drive(0, 1, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    idle();
  endtask

  // R9: several words in one transaction
  task automatic reg_wr3(input logic [15:0] ra, input logic [15:0] a, b, c);
    send_addr(ra);
    send_word(ra, a);
    send_word(ra, b);
    send_word(ra, c);
    drive(0, 1, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    idle();
  endtask

  // R10: address write then repeated start in read mode; R6 byte order
  task automatic reg_rd(input string tag, input logic [15:0] ra);
    logic [15:0] ev;
    logic isport;
    isport = (ra == A_PORT);
    send_addr(ra);
    ev = m_val(ra);
    drive(1, 0, 1, 0, 8'h00, 0, 0, isport, m_rp, '0);
    if (isport) m_rp = m_rp + 32'd2;
    drive(0, 0, 0, 0, 8'h00, 1, 0, 0, '0, '0);
    #2 chk({tag, " high byte"}, {8'h00, o_rd_byte}, {8'h00, ev[15:8]});
    drive(0, 0, 0, 0, 8'h00, 1, 0, 0, '0, '0);
    #2 chk({tag, " low byte"}, {8'h00, o_rd_byte}, {8'h00, ev[7:0]});
    drive(0, 1, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    #2 chk("R6 third byte repeats high", {8'h00, o_rd_byte}, {8'h00, ev[15:8]});
    idle();
  endtask

  initial begin
    #(CLK_PER * 50000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    i_start = 0; i_stop = 0; i_rnw = 0; i_wr_vld = 0; i_wr_byte = '0; i_rd_req = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 reset we", {15'd0, o_mem_we}, 16'h0000);
    chk("R11 reset re", {15'd0, o_mem_re}, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    reg_rd("R7 page reset", A_PAGE);
    reg_wr(A_PAGE, 16'h1234);
    reg_rd("R7 R1 page write", A_PAGE);

    reg_wr(A_WH, 16'h7000);
    reg_wr(A_WL, 16'h0250);
    reg_wr(A_PORT, 16'hA1A1);
    reg_wr(A_PORT, 16'hB2B2);
    reg_rd("R4 R2 wptr low after two writes", A_WL);
    reg_rd("R2 wptr high", A_WH);

    reg_wr(A_WL, 16'h0100);
    reg_rd("R3 high kept after low write", A_WH);
    reg_wr(A_WH, 16'h6000);
    reg_rd("R3 low kept after high write", A_WL);

    reg_wr3(A_PORT, 16'h1111, 16'h2222, 16'h3333);
    reg_rd("R9 burst advanced pointer", A_WL);

    reg_wr(A_RH, 16'h6000);
    reg_wr(A_RL, 16'h0100);
    reg_rd("R2 rptr low", A_RL);
    reg_rd("R5 port read 1", A_PORT);
    reg_rd("R5 port read 2", A_PORT);
    reg_rd("R5 port read 3", A_PORT);
    reg_rd("R5 port read unwritten", A_PORT);
    reg_rd("R5 rptr advanced", A_RL);

    reg_wr(A_WH, 16'h7000);
    reg_wr(A_WL, 16'hFFFE);
    reg_wr(A_PORT, 16'hC3C3);
    reg_rd("R4 carry into high", A_WH);
    reg_rd("R4 low wraps", A_WL);

    reg_wr(16'h1234, 16'hBEEF);
    reg_rd("R8 unmapped reads zero", 16'h1234);
    reg_rd("R8 wptr untouched", A_WL);
    reg_rd("R8 page untouched", A_PAGE);

    // R10: stop after a lone address byte, then a fresh transaction
    drive(1, 0, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    drive(0, 0, 0, 1, 8'h0F, 0, 0, 0, '0, '0);
    drive(0, 1, 0, 0, 8'h00, 0, 0, 0, '0, '0);
    idle();
    reg_wr(A_PAGE, 16'h5555);
    reg_rd("R10 phase reset by stop", A_PAGE);

    repeat (3) idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule